// File: doc/BRIEF.md
# Conditional Call and Return Unit

This unit resolves the control-flow instructions of a simple in-order core: a conditional forward jump, a conditional call and a return. For each valid instruction, the unit evaluates one of eight conditions on the 32-bit register operand B and the 32-bit immediate. It then reports whether the instruction is taken, gives the program counter of the next instruction, and gives the value to write to the destination. Instructions are 16 bytes wide. A forward branch moves the pc by a multiple of 16 bytes, and that multiple is encoded in the low seven bits of the 8-bit immediate.

A bounded return stack is held inside the unit. Each entry holds a return address and a saved copy of operand A. A taken call pushes one entry. A taken return pops one entry, jumps to the saved address, and writes A XOR the saved value to the destination. In every case where the instruction is not taken, it behaves as a move of A to the destination, and the pc advances by one instruction. The decision and the outputs are combinational from the current inputs and the stack state. The stack itself changes on the rising clock edge.

Top module: `cond_flow_unit`

## Requirements
- R1: Condition select 0 is taken when B <= imm32 and condition select 1 when B > imm32, both compared as unsigned 32-bit values.
- R2: Condition select 2 is taken when bit 31 of the 32-bit difference B - imm32 is set, and condition select 3 when it is clear.
- R3: Condition select 4 is taken when B - imm32 overflows as a signed 32-bit subtraction, and condition select 5 when it does not.
- R4: Condition select 6 is taken when B < imm32 and condition select 7 when B >= imm32, both compared as signed 32-bit values.
- R5: With op_i = 0 (jump), a taken instruction gives next_pc_o = pc_i + 16*(imm8_i[6:0]+1); bit 7 of imm8_i is ignored; c_o = a_i.
- R6: With op_i = 1 (call), a taken instruction gives next_pc_o = pc_i + 16*(imm8_i[6:0]+1) and c_o = a_i, and pushes the pair (pc_i+16, a_i) onto the stack.
- R7: With op_i = 2 (return) and a non-empty stack, the instruction is taken: it pops the newest entry, and next_pc_o is that entry's address and c_o is a_i XOR that entry's saved value; entries come back in last-in first-out order.
- R8: A return with an empty stack is not taken.
- R9: Whenever taken_o is low, c_o = a_i and next_pc_o = pc_i + 16, and the stack is unchanged.
- R10: stack_full_o is high when DEPTH entries are held; a call made then is not taken and leaves the stack unchanged.
- R11: After reset the stack is empty and stack_full_o is low.
- R12: With valid_i low, or with op_i = 3 (pass), taken_o is low and the stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 2 | 0 jump, 1 call, 2 return, 3 pass |
| cond_i | input | 3 | Condition select for jump and call |
| pc_i | input | PC_W | Address of the current instruction |
| a_i | input | DATA_W | Operand A |
| b_i | input | 32 | Low 32 bits of register operand B |
| imm32_i | input | 32 | 32-bit immediate |
| imm8_i | input | 8 | 8-bit immediate, forward offset in bits 6:0 |
| next_pc_o | output | PC_W | Address of the next instruction |
| taken_o | output | 1 | Instruction is taken |
| c_o | output | DATA_W | Value for the destination |
| stack_full_o | output | 1 | Return stack holds DEPTH entries |

## Verification
The assertions assume that op_i, cond_i and the operands do not change while the clock edge is sampled. They also assume that pc_i does not sit within 2 KiB of the top of the address space, so that a forward jump never wraps to a lower address. The bench changes every input only on the falling edge. It keeps every pc well below the wrap point, and it fills the stack to exactly DEPTH entries before it tries one more call.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    OP_JUMP = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_PASS = 2'd3
  } cfu_op_e;

  localparam int CMP_W   = 32;
  localparam int OFF_W   = 7;
  localparam int STEP_LG = 4;  // 16-byte instructions
endpackage

// File: rtl/cfu_cond.sv
module cfu_cond import cfu_pkg::*; (
  input  logic [2:0]       sel_i,
  input  logic [CMP_W-1:0] b_i,
  input  logic [CMP_W-1:0] imm_i,
  output logic             hit_o
);
  logic [CMP_W-1:0] diff;
  logic neg, ovf, slt, ule;

  assign diff = b_i - imm_i;
  assign neg  = diff[CMP_W-1];
  assign ovf  = (b_i[CMP_W-1] != imm_i[CMP_W-1]) && (diff[CMP_W-1] != b_i[CMP_W-1]);
  assign slt  = neg ^ ovf;
  assign ule  = (b_i <= imm_i);

  always_comb begin
    unique case (sel_i)
      3'd0: hit_o = ule;
      3'd1: hit_o = !ule;
      3'd2: hit_o = neg;
      3'd3: hit_o = !neg;
      3'd4: hit_o = ovf;
      3'd5: hit_o = !ovf;
      3'd6: hit_o = slt;
      default: hit_o = !slt;
    endcase
  end
endmodule

// File: rtl/cfu_stack.sv
module cfu_stack #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic [DATA_W-1:0] top_data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  wr_idx, top_idx;

  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + 1'b1;
    else if (pop_i)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_mem[wr_idx] <= push_addr_i;
      data_mem[wr_idx] <= push_data_i;
    end
  end

  assign top_addr_o = (cnt_q != '0) ? addr_mem[top_idx] : '0;
  assign top_data_o = (cnt_q != '0) ? data_mem[top_idx] : '0;
  assign count_o    = cnt_q;
endmodule

// File: rtl/cond_flow_unit.sv
module cond_flow_unit import cfu_pkg::*; #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        cond_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [31:0]       b_i,
  input  logic [31:0]       imm32_i,
  input  logic [7:0]        imm8_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] c_o,
  output logic              stack_full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  cfu_op_e           op;
  logic              hit, full, empty, push, pop;
  logic [CNT_W-1:0]  depth_w;
  logic [PC_W-1:0]   seq_pc, fwd_pc, top_addr;
  logic [DATA_W-1:0] top_data;
  logic [PC_W-1:0]   offset;

  assign op = cfu_op_e'(op_i);

  cfu_cond u_cond (
    .sel_i (cond_i),
    .b_i   (b_i),
    .imm_i (imm32_i),
    .hit_o (hit)
  );

  assign full   = (depth_w == CNT_W'(DEPTH));
  assign empty  = (depth_w == '0);
  assign offset = PC_W'({1'b0, imm8_i[OFF_W-1:0]} + 8'd1) << STEP_LG;
  assign seq_pc = pc_i + PC_W'(1 << STEP_LG);
  assign fwd_pc = pc_i + offset;

  always_comb begin
    unique case (op)
      OP_JUMP: taken_o = valid_i && hit;
      OP_CALL: taken_o = valid_i && hit && !full;
      OP_RET:  taken_o = valid_i && !empty;
      default: taken_o = 1'b0;
    endcase
  end

  assign push = taken_o && (op == OP_CALL);
  assign pop  = taken_o && (op == OP_RET);

  always_comb begin
    next_pc_o = seq_pc;
    c_o       = a_i;
    if (taken_o) begin
      if (pop) begin
        next_pc_o = top_addr;
        c_o       = a_i ^ top_data;
      end else begin
        next_pc_o = fwd_pc;
      end
    end
  end

  cfu_stack #(
    .ADDR_W (PC_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_addr_i (seq_pc),
    .push_data_i (a_i),
    .top_addr_o  (top_addr),
    .top_data_o  (top_data),
    .count_o     (depth_w)
  );

  assign stack_full_o = full;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DATA_W-1:0] a_i,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              taken_o,
  input logic [DATA_W-1:0] c_o,
  input logic              stack_full_o,
  input logic [CNT_W-1:0]  depth_i
);
  logic [PC_W-1:0] jump_dist;
  assign jump_dist = next_pc_o - pc_i;

  AST_RET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd2 && depth_i == '0 |-> !taken_o); // R8

  AST_NOT_TAKEN_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> next_pc_o == pc_i + PC_W'(16) && c_o == a_i); // R9

  AST_CALL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && op_i == 2'd1 |=> depth_i == $past(depth_i) + 1'b1); // R6

  AST_RET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && op_i == 2'd2 |=> depth_i == $past(depth_i) - 1'b1); // R7

  AST_STACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_o && (op_i == 2'd1 || op_i == 2'd2)) |=> $stable(depth_i)); // R9

  AST_FULL_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_o && op_i == 2'd1 |-> !taken_o); // R10

  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 2'd3) |-> !taken_o); // R12

  AST_JUMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && op_i == 2'd0 |-> jump_dist >= PC_W'(16) && jump_dist <= PC_W'(2048)
      && jump_dist[3:0] == 4'd0); // R5
endmodule

bind cond_flow_unit cfu_checker #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .pc_i         (pc_i),
  .a_i          (a_i),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .c_o          (c_o),
  .stack_full_o (stack_full_o),
  .depth_i      (depth_w)
);

// File: tb/sim_cond_flow_unit.sv
module sim_cond_flow_unit;
  localparam int PC_W = 32, DATA_W = 64, DEPTH = 16;

  logic              clk = 1'b0, rst_ni = 1'b0, valid = 1'b0;
  logic [1:0]        op = 2'd3;
  logic [2:0]        cond = '0;
  logic [PC_W-1:0]   pc = '0;
  logic [DATA_W-1:0] a = '0;
  logic [31:0]       b = '0, imm32 = '0;
  logic [7:0]        imm8 = '0;
  logic [PC_W-1:0]   next_pc;
  logic              taken, full;
  logic [DATA_W-1:0] c;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_flow_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .op_i(op), .cond_i(cond),
    .pc_i(pc), .a_i(a), .b_i(b), .imm32_i(imm32), .imm8_i(imm8),
    .next_pc_o(next_pc), .taken_o(taken), .c_o(c), .stack_full_o(full)
  );

  // {cond, b, imm32, expected taken}
  localparam logic [67:0] VEC [16] = '{
    {3'd0, 32'd5,        32'd5,        1'b1},  // R1
    {3'd0, 32'd6,        32'd5,        1'b0},  // R1
    {3'd0, 32'hFFFFFFFF, 32'd1,        1'b0},  // R1
    {3'd1, 32'hFFFFFFFF, 32'd1,        1'b1},  // R1
    {3'd1, 32'd3,        32'd3,        1'b0},  // R1
    {3'd2, 32'd3,        32'd5,        1'b1},  // R2
    {3'd2, 32'd5,        32'd3,        1'b0},  // R2
    {3'd3, 32'd5,        32'd5,        1'b1},  // R2
    {3'd3, 32'd0,        32'd1,        1'b0},  // R2
    {3'd4, 32'h80000000, 32'd1,        1'b1},  // R3
    {3'd4, 32'd5,        32'd3,        1'b0},  // R3
    {3'd5, 32'h80000000, 32'd1,        1'b0},  // R3
    {3'd5, 32'd7,        32'd2,        1'b1},  // R3
    {3'd6, 32'h80000000, 32'd1,        1'b1},  // R4
    {3'd6, 32'd1,        32'hFFFFFFFF, 1'b0},  // R4
    {3'd7, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0}   // R4
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] o, input logic [2:0] cd, input logic [PC_W-1:0] p,
                     input logic [63:0] av, input logic [31:0] bv, input logic [31:0] iv,
                     input logic [7:0] i8);
    @(negedge clk);
    valid = 1'b1; op = o; cond = cd; pc = p; a = av; b = bv; imm32 = iv; imm8 = i8;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; op = 2'd3;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] exp_pc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // reset state, R11 and R8
    put(2'd2, 3'd0, 32'h40, 64'h55, 0, 0, 0);
    chk(!full, "R11 full after reset", 64'(full), 0);
    chk(!taken, "R8 ret on empty", 64'(taken), 0);
    chk(next_pc == 32'h50 && c == 64'h55, "R9 empty ret moves A", c, 64'h55);

    // condition table walked by jumps
    for (int i = 0; i < 16; i++) begin
      logic [67:0] v = VEC[i];
      put(2'd0, v[67:65], 32'h1000, 64'hA5A5, v[64:33], v[32:1], 8'(i));
      exp_pc = v[0] ? 32'h1000 + 32'(16 * (i + 1)) : 32'h1010;
      chk(taken == v[0], $sformatf("R1-4 cond %0d vector %0d taken", v[67:65], i), 64'(taken), 64'(v[0]));
      chk(next_pc == exp_pc && c == 64'hA5A5, "R5 R9 jump pc", 64'(next_pc), 64'(exp_pc));
    end

    // R5 offset bounds, bit 7 ignored
    put(2'd0, 3'd3, 32'h1000, 0, 0, 0, 8'hFF);
    chk(next_pc == 32'h1800, "R5 max offset", 64'(next_pc), 64'h1800);
    put(2'd0, 3'd3, 32'h1000, 0, 0, 0, 8'h80);
    chk(next_pc == 32'h1010, "R5 bit7 ignored", 64'(next_pc), 64'h1010);

    // R12: invalid and pass do nothing
    @(negedge clk);
    valid = 1'b0; op = 2'd1; cond = 3'd3; b = 0; imm32 = 0; pc = 32'h300; #1;
    chk(!taken, "R12 invalid call", 64'(taken), 0);
    put(2'd3, 3'd3, 32'h300, 64'h7, 0, 0, 0);
    chk(!taken && c == 64'h7, "R12 pass op", c, 64'h7);
    put(2'd2, 3'd0, 32'h300, 0, 0, 0, 0);
    chk(!taken, "R12 stack still empty", 64'(taken), 0);

    // R6/R7 nested call and return, LIFO
    put(2'd1, 3'd3, 32'h100, 64'h1111, 0, 0, 8'd3);
    chk(taken && next_pc == 32'h140 && c == 64'h1111, "R6 call one", 64'(next_pc), 64'h140);
    put(2'd1, 3'd3, 32'h200, 64'h2222, 0, 0, 8'd0);
    chk(taken && next_pc == 32'h210, "R6 call two", 64'(next_pc), 64'h210);
    put(2'd2, 3'd0, 32'h500, 64'hF0F0, 0, 0, 0);
    chk(taken && next_pc == 32'h210, "R7 ret to second", 64'(next_pc), 64'h210);
    chk(c == (64'hF0F0 ^ 64'h2222), "R7 ret value two", c, 64'hF0F0 ^ 64'h2222);
    put(2'd2, 3'd0, 32'h600, 64'h0F0F, 0, 0, 0);
    chk(taken && next_pc == 32'h110, "R7 ret to first", 64'(next_pc), 64'h110);
    chk(c == (64'h0F0F ^ 64'h1111), "R7 ret value one", c, 64'h0F0F ^ 64'h1111);
    put(2'd1, 3'd2, 32'h700, 64'h9, 32'd5, 32'd3, 0);
    chk(!taken && next_pc == 32'h710, "R9 call not taken", 64'(next_pc), 64'h710);
    put(2'd2, 3'd0, 32'h800, 0, 0, 0, 0);
    chk(!taken, "R8 ret empty again", 64'(taken), 0);

    // R10 fill the stack
    for (int k = 0; k < DEPTH; k++) begin
      put(2'd1, 3'd3, 32'h2000 + 32'(k * 256), 64'(k + 1), 0, 0, 0);
      chk(taken, "R10 fill call", 64'(taken), 1);
    end
    idle();
    chk(full, "R10 full flag", 64'(full), 1);
    put(2'd1, 3'd3, 32'h9000, 64'hDEAD, 0, 0, 8'd5);
    chk(!taken && next_pc == 32'h9010 && c == 64'hDEAD, "R10 call when full", 64'(next_pc), 64'h9010);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      put(2'd2, 3'd0, 32'hA000, 64'h0, 0, 0, 0);
      exp_pc = 32'h2010 + 32'(k * 256);
      chk(taken && next_pc == exp_pc, "R7 R10 unwind pc", 64'(next_pc), 64'(exp_pc));
      chk(c == 64'(k + 1), "R7 unwind value", c, 64'(k + 1));
    end
    put(2'd2, 3'd0, 32'hA000, 0, 0, 0, 0);
    chk(!taken && !full, "R8 empty after unwind", 64'(taken), 0);
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule